// File: doc/BRIEF.md
# Keyed Reset and Priority-Split Control Register

This block is a single 32-bit control word that sits on a plain register bus. A write takes effect only when the upper half of the write data carries the 16-bit unlock value 0x05FA. Any other write is dropped whole. Reads never return the unlock value. The upper half always reads back as the fixed signature 0xFA05, whatever was last written.

The word holds a 3-bit code that sets how an 8-bit interrupt priority divides into pre-emption and sub-priority bits. The block drives that code, and a decoded mask of the pre-emption bits, to a downstream priority comparator. The same word raises three requests:
- a system reset request that is held until the reset generator answers with a warm reset;
- a one-cycle strobe that clears all active-exception state;
- a one-cycle strobe that resets the core but leaves the debug logic alone.

The register also reports a fixed byte-order status bit, which shows little endian.

Top module: `keyed_rst_ctl`

## Requirements
- R1: A write (wr_en high) is accepted only when wdata[31:16] equals 0x05FA. Any other value leaves the grouping code and the reset request unchanged, and raises no strobe.
- R2: rdata[31:16] always reads 0xFA05.
- R3: rdata[15] is the byte-order flag, fixed at 0 (little endian), and no write changes it. rdata[14:11], rdata[7:3], rdata[1] and rdata[0] always read 0.
- R4: The grouping code is written through wdata[10:8], read back on rdata[10:8] and driven on grp. Power-on reset (por_n low) sets it to 000.
- R5: pre_mask has bit i set exactly when i is greater than grp. For code N this gives 7-N pre-emption bits at the top of the 8-bit priority, and code 111 gives none.
- R6: An accepted write with wdata[2]=1 raises sys_rst_req from the clock edge that takes the write. The request then stays high, and reads as 1 on rdata[2], until warm_rst is sampled high. An accepted write with wdata[2]=0 does not clear a pending request.
- R7: An accepted write with wdata[1]=1 drives clr_active high for exactly the one cycle that follows the write edge.
- R8: An accepted write with wdata[0]=1 drives local_rst high for exactly the one cycle that follows the write edge.
- R9: A warm reset leaves the grouping code unchanged. Only power-on reset clears it.
- R10: When warm_rst is high at a clock edge, that edge clears sys_rst_req, clr_active and local_rst, and a write in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset from the reset generator, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wdata | input | 32 | Write data; key in [31:16] |
| rdata | output | 32 | Read-back of the control word |
| grp | output | 3 | Priority grouping code |
| pre_mask | output | 8 | Pre-emption bit mask of the 8-bit priority |
| sys_rst_req | output | 1 | Held system reset request |
| clr_active | output | 1 | One-cycle clear-active-state strobe |
| local_rst | output | 1 | One-cycle local reset strobe |

## Verification
A keyed write and a warm reset can arrive in the same cycle. The stimulus provokes this both on purpose and at random: a valid key with all request bits set and a new grouping code is written in a cycle where warm_rst is high. The expected outcome is that the reset request ends low, that no strobe appears in the next cycle, and that the grouping code keeps its old value. Random runs mix valid and invalid keys with sporadic warm resets, so the collision recurs under many register states.

// File: rtl/keyed_rst_ctl.sv
module keyed_rst_ctl #(
  parameter logic [15:0] WR_KEY  = 16'h05FA,
  parameter logic [15:0] RD_SIG  = 16'hFA05,
  parameter bit          BIG_END = 1'b0
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        warm_rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [2:0]  grp,
  output logic [7:0]  pre_mask,
  output logic        sys_rst_req,
  output logic        clr_active,
  output logic        local_rst
);
  localparam int GRP_W  = 3;
  localparam int PRIO_W = 1 << GRP_W;

  logic             accept;
  logic [GRP_W-1:0] grp_q;
  logic             req_q, clr_q, lrst_q;
  logic             unused_bits;

  assign accept      = wr_en && !warm_rst && (wdata[31:16] == WR_KEY);
  assign unused_bits = ^{wdata[15:11], wdata[7:3]};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      grp_q <= '0;
    else if (accept)
      grp_q <= wdata[10:8];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      req_q  <= 1'b0;
      clr_q  <= 1'b0;
      lrst_q <= 1'b0;
    end else if (warm_rst) begin
      req_q  <= 1'b0;
      clr_q  <= 1'b0;
      lrst_q <= 1'b0;
    end else begin
      req_q  <= req_q | (accept & wdata[2]);
      clr_q  <= accept & wdata[1];
      lrst_q <= accept & wdata[0];
    end
  end

  for (genvar i = 0; i < PRIO_W; i++) begin : g_mask
    assign pre_mask[i] = (GRP_W'(i) > grp_q);
  end

  assign grp         = grp_q;
  assign sys_rst_req = req_q;
  assign clr_active  = clr_q;
  assign local_rst   = lrst_q;
  assign rdata       = {RD_SIG, BIG_END, 4'b0, grp_q, 5'b0, req_q, 2'b0};
endmodule

module keyed_rst_ctl_chk (
  input logic        clk,
  input logic        por_n,
  input logic        warm_rst,
  input logic        wr_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic [2:0]  grp,
  input logic [7:0]  pre_mask,
  input logic        sys_rst_req,
  input logic        clr_active,
  input logic        local_rst
);
  // R1
  bad_key_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wdata[31:16] != 16'h05FA) |=> ($stable(grp) && !clr_active && !local_rst));
  // R2
  sig_chk: assert property (@(posedge clk) disable iff (!por_n)
    rdata[31:16] == 16'hFA05);
  // R5
  mask_width_chk: assert property (@(posedge clk) disable iff (!por_n)
    $countones(pre_mask) == 7 - int'(grp));
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_req && !warm_rst) |=> sys_rst_req);
  // R7
  clr_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    clr_active |-> $past(wr_en && !warm_rst && wdata[31:16] == 16'h05FA && wdata[1]));
  // R8
  lrst_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    local_rst |-> $past(wr_en && !warm_rst && wdata[31:16] == 16'h05FA && wdata[0]));
  // R9
  grp_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> $stable(grp));
  // R10
  warm_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> (!sys_rst_req && !clr_active && !local_rst));
endmodule

bind keyed_rst_ctl keyed_rst_ctl_chk u_chk (
  .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .grp(grp), .pre_mask(pre_mask), .sys_rst_req(sys_rst_req),
  .clr_active(clr_active), .local_rst(local_rst)
);

// File: tb/sim_keyed_rst_ctl.sv
module sim_keyed_rst_ctl;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  grp;
  logic [7:0]  pre_mask;
  logic        sys_rst_req, clr_active, local_rst;

  int checks = 0;
  int failures = 0;
  logic [2:0] m_grp = 3'd0;
  logic       m_req = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  keyed_rst_ctl u0 (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .grp(grp), .pre_mask(pre_mask), .sys_rst_req(sys_rst_req),
    .clr_active(clr_active), .local_rst(local_rst)
  );

  function automatic logic [31:0] exp_rd(logic [2:0] g, logic r);
    logic [31:0] v = 32'h0;
    v[31:16] = 16'hFA05;
    v[10:8]  = g;
    v[2]     = r;
    return v;
  endfunction

  function automatic logic [7:0] exp_mask(logic [2:0] g);
    logic [7:0] m = 8'h00;
    for (int i = 0; i < 8; i++) if (i > int'(g)) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk({tag, " R4 grp"}, 32'(grp), 32'(m_grp));
    chk({tag, " R2/R3 rdata"}, rdata, exp_rd(m_grp, m_req));
    chk({tag, " R5 mask"}, 32'(pre_mask), 32'(exp_mask(m_grp)));
    chk({tag, " R6 req"}, 32'(sys_rst_req), 32'(m_req));
  endtask

  task automatic cycle(logic [31:0] d, logic we, logic warm);
    logic ok;
    @(negedge clk);
    wr_en = we; wdata = d; warm_rst = warm;
    ok = we && !warm && d[31:16] == 16'h05FA;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; warm_rst = 1'b0; wdata = $urandom;
    if (warm) m_req = 1'b0;
    else if (ok) begin
      m_grp = d[10:8];
      if (d[2]) m_req = 1'b1;
    end
    chk("R7/R10 clr strobe", 32'(clr_active), 32'(ok && d[1]));
    chk("R8/R10 lrst strobe", 32'(local_rst), 32'(ok && d[0]));
    check_state("post-write");
    @(posedge clk);
    @(negedge clk);
    chk("R7 clr one cycle", 32'(clr_active), 32'h0);
    chk("R8 lrst one cycle", 32'(local_rst), 32'h0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    #9;
    check_state("reset R4");
    chk("reset R7", 32'(clr_active), 0);
    chk("reset R8", 32'(local_rst), 0);
    por_n = 1'b1;

    cycle(32'h05FA_0500, 1, 0);
    cycle(32'hFA05_0307, 1, 0);              // R1 signature is not the key
    cycle(32'hFFFF_FFFF, 1, 0);              // R1 R3 all ones rejected
    cycle(32'h05FA_FFFB, 1, 0);              // R3 reserved bits written
    cycle(32'h05FA_0002, 1, 0);              // R7
    cycle(32'h05FA_0001, 1, 0);              // R8
    cycle(32'h05FA_0104, 1, 0);              // R6 raise
    cycle(32'h05FA_0200, 1, 0);              // R6 zero does not clear
    cycle(32'h0000_0000, 0, 1);              // R9 R10 warm reset
    cycle(32'h05FA_0707, 1, 1);              // R10 collision
    for (int g = 0; g < 8; g++) cycle({16'h05FA, 5'b0, 3'(g), 8'h00}, 1, 0); // R5

    for (int n = 0; n < 300; n++) begin
      logic [31:0] d = $urandom;
      if ($urandom_range(1, 0) == 1) d[31:16] = 16'h05FA;
      cycle(d, $urandom_range(3, 0) != 0, $urandom_range(9, 0) == 0);
    end

    @(negedge clk);
    por_n = 1'b0;
    m_grp = 3'd0; m_req = 1'b0;
    #1;
    check_state("por R4");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule